// File: doc/BRIEF.md
# Gated Encoder Counter with Selectable Clear

This block keeps a signed present value (PV) for an incremental encoder channel. Up and down pulse strobes, already decoded, move the PV by one step each. A hold input freezes the count. A software clear bit can zero the count in one of two ways, chosen by a mode input. In software mode, the bit is looked at once per scan. In index mode, the bit enables the encoder's index (phase-Z) pulse to zero the count.

A scan strobe marks the boundary of each control cycle. At each strobe the block compares the PV with the value it saved at the previous strobe. It then updates a direction flag that tells the host whether the count rose or fell over that cycle. All inputs are synchronous to one clock. The asynchronous active-low reset is released through an internal synchronizer.

Top module: `gec_counter`

## Requirements
- R1: While reset is applied, `pv` reads 0 and `dir_up` reads 0. Both stay at those values until the first counting event after reset is released.
- R2: In a cycle with no clear and no effective hold, `pv` changes on the next clock edge as follows: +1 if only `cnt_up` is 1, −1 if only `cnt_dn` is 1, and no change if both or neither are 1. `pv` is a two's-complement value.
- R3: With `clr_mode`=0 (software mode), `sw_clr` is sampled only on cycles where `scan` is 1. `pv` becomes 0 after a scan in which the sample is 1 and the sample from the previous scan was 0. That previous sample reads 0 after reset. A held 1, or a 1 present outside a scan, does not clear.
- R4: With `clr_mode`=1 (index mode), `pv` becomes 0 after any cycle in which `idx_z` and `sw_clr` are both 1. Either input alone has no effect. In software mode, `idx_z` has no effect.
- R5: While `hold` is 1, count strobes are ignored and `pv` keeps its value. When `hold` returns to 0, counting continues from that value. A software-mode clear still acts while `hold` is 1.
- R6: When a clear and a count strobe fall in the same cycle, the clear wins and `pv` becomes 0.
- R7: In index mode with `sw_clr` at 1, `hold` has no effect and count strobes are applied.
- R8: On a cycle with `scan` at 1, `pv` is compared, as signed values, with the value saved at the previous scan (0 after reset). One cycle later `dir_up` is 1 if `pv` was greater, 0 if it was smaller, and unchanged if they were equal. `dir_up` changes only after a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_up | input | 1 | Count-up strobe |
| cnt_dn | input | 1 | Count-down strobe |
| idx_z | input | 1 | Encoder index (phase-Z) pulse |
| sw_clr | input | 1 | Software clear bit |
| hold | input | 1 | Hold (gate) bit |
| clr_mode | input | 1 | Clear method: 0 software, 1 index |
| scan | input | 1 | One-cycle scan strobe |
| pv | output | PV_W (32) | Signed present value |
| dir_up | output | 1 | Direction flag, 1 rising, 0 falling |

## Verification
Counting is exercised with four strobe patterns: up only, down only, both together, and held. Together they separate a correct net step from a design that lets one strobe dominate the other. The clear bit is driven in several ways: held across scans, raised between scans, and paired with or without the index pulse in each mode. This shows the edge sampling is tied to the scan and that the index pulse is qualified correctly. Scans are placed after a rise, a fall, no change, and a move from negative to zero. These cases show that the direction comparison is signed and that the flag is kept when the PV is equal.

// File: rtl/gec_pkg.sv
package gec_pkg;

  typedef enum logic {
    CLR_SOFT  = 1'b0,
    CLR_INDEX = 1'b1
  } clr_mode_e;

  function automatic logic signed [1:0] step_of(input logic up, input logic dn);
    logic signed [1:0] s;
    if (up && !dn)      s = 2'sd1;
    else if (dn && !up) s = -2'sd1;
    else                s = 2'sd0;
    return s;
  endfunction

endpackage

// File: rtl/gec_rst_sync.sv
module gec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gec_clear_ctrl.sv
module gec_clear_ctrl
  import gec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      idx_z,
  input  logic      sw_clr,
  input  logic      hold,
  input  clr_mode_e mode,
  input  logic      scan,
  output logic      clr_now,
  output logic      cnt_en
);
  logic smp_q, smp_d;
  logic soft_clr, idx_clr, hold_over;

  always_comb begin
    smp_d = smp_q;
    if (scan) smp_d = sw_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    smp_q <= 1'b0;
    else if (scan) smp_q <= smp_d;
  end

  always_comb begin
    soft_clr  = (mode == CLR_SOFT)  && scan && sw_clr && !smp_q;
    idx_clr   = (mode == CLR_INDEX) && idx_z && sw_clr;
    hold_over = (mode == CLR_INDEX) && sw_clr;
    clr_now   = soft_clr || idx_clr;
    cnt_en    = !hold || hold_over;
  end
endmodule

// File: rtl/gec_pv_reg.sv
module gec_pv_reg
  import gec_pkg::*;
#(
  parameter int PV_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_now,
  input  logic                   cnt_en,
  input  logic                   cnt_up,
  input  logic                   cnt_dn,
  output logic signed [PV_W-1:0] pv
);
  logic signed [PV_W-1:0] pv_q, pv_d;
  logic signed [1:0]      step;
  logic                   pv_ce;

  always_comb begin
    step  = step_of(cnt_up, cnt_dn);
    pv_ce = clr_now || (cnt_en && (step != 2'sd0));
    if (clr_now) pv_d = '0;
    else         pv_d = pv_q + PV_W'(step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pv_q <= '0;
    else if (pv_ce) pv_q <= pv_d;
  end

  assign pv = pv_q;
endmodule

// File: rtl/gec_dir_track.sv
module gec_dir_track #(
  parameter int PV_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scan,
  input  logic signed [PV_W-1:0] pv,
  output logic                   dir_up
);
  logic signed [PV_W-1:0] snap_q;
  logic                   dir_q, dir_d;

  always_comb begin
    dir_d = dir_q;
    if (pv > snap_q)      dir_d = 1'b1;
    else if (pv < snap_q) dir_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      dir_q  <= 1'b0;
    end else if (scan) begin
      snap_q <= pv;
      dir_q  <= dir_d;
    end
  end

  assign dir_up = dir_q;
endmodule

// File: rtl/gec_counter.sv
module gec_counter
  import gec_pkg::*;
#(
  parameter int PV_W        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cnt_up,
  input  logic                   cnt_dn,
  input  logic                   idx_z,
  input  logic                   sw_clr,
  input  logic                   hold,
  input  logic                   clr_mode,
  input  logic                   scan,
  output logic signed [PV_W-1:0] pv,
  output logic                   dir_up
);
  logic      rst_i_n;
  logic      clr_now, cnt_en;
  clr_mode_e mode;

  assign mode = clr_mode_e'(clr_mode);

  gec_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  gec_clear_ctrl u_clr (
    .clk(clk), .rst_n(rst_i_n), .idx_z(idx_z), .sw_clr(sw_clr),
    .hold(hold), .mode(mode), .scan(scan),
    .clr_now(clr_now), .cnt_en(cnt_en)
  );

  gec_pv_reg #(.PV_W(PV_W)) u_pv (
    .clk(clk), .rst_n(rst_i_n), .clr_now(clr_now), .cnt_en(cnt_en),
    .cnt_up(cnt_up), .cnt_dn(cnt_dn), .pv(pv)
  );

  gec_dir_track #(.PV_W(PV_W)) u_dir (
    .clk(clk), .rst_n(rst_i_n), .scan(scan), .pv(pv), .dir_up(dir_up)
  );
endmodule

// File: rtl/gec_counter_chk.sv
module gec_counter_chk #(
  parameter int PV_W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cnt_up,
  input logic                   cnt_dn,
  input logic                   idx_z,
  input logic                   sw_clr,
  input logic                   hold,
  input logic                   clr_mode,
  input logic                   scan,
  input logic signed [PV_W-1:0] pv,
  input logic                   dir_up
);
  logic last_smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_smp <= 1'b0;
    else if (scan) last_smp <= sw_clr;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_zero: assert (pv == '0 && dir_up == 1'b0);
    end
  end

  a_r3_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_mode && scan && sw_clr && !last_smp) |=> (pv == '0));

  a_r4_index_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mode && sw_clr && idx_z) |=> (pv == '0));

  a_r5_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !sw_clr) |=> $stable(pv));

  a_r7_hold_override: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mode && sw_clr && !idx_z && hold && cnt_up && !cnt_dn)
      |=> (pv == $past(pv) + 1));

  a_r2_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !sw_clr && cnt_dn && !cnt_up) |=> (pv == $past(pv) - 1));

  a_r8_dir_only_on_scan: assert property (@(posedge clk) disable iff (!rst_n)
    !scan |=> $stable(dir_up));
endmodule

bind gec_counter gec_counter_chk #(.PV_W(PV_W)) u_chk (.*);

// File: tb/tb_gec_counter.sv
module tb_gec_counter;
  localparam int PV_W = 32;

  typedef struct packed {
    logic up, dn, z, sw, hold, mode, scan;
    int   pv;
    logic dir;
    int   req;
  } vec_t;

  localparam int NV = 27;
  // fields: up dn z sw hold mode scan | expected pv dir | requirement
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,  1,1'b0,2}, // R2 up
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,  2,1'b0,2},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,  3,1'b1,8}, // R8 rise
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,  2,1'b1,2}, // R2 down
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,  1,1'b1,2},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,  1,1'b0,8}, // R8 fall
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,  1,1'b0,2}, // R2 both
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,  1,1'b0,8}, // R8 equal keeps
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,  1,1'b0,5}, // R5 hold
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,  1,1'b0,5},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,  2,1'b0,5}, // R5 resume
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,  2,1'b0,3}, // R3 no scan
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,  0,1'b1,6}, // R6 / R3 clear
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,  1,1'b1,2},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,  1,1'b0,3}, // R3 held 1
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,  1,1'b0,8},
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,  2,1'b0,4}, // R4 z alone
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,  3,1'b0,4}, // R4 sw alone
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,  4,1'b0,7}, // R7 override
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,  0,1'b0,6}, // R6 / R4 clear
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,  0,1'b0,5}, // R5 index mode
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,  1,1'b0,4}, // R4 z ignored soft
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,  0,1'b0,2},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, -1,1'b0,2}, // R2 negative
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, -1,1'b0,8},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,  0,1'b0,2},
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,  0,1'b1,8}  // R8 signed rise
  };

  logic clk, rst_n, cnt_up, cnt_dn, idx_z, sw_clr, hold, clr_mode, scan;
  logic signed [PV_W-1:0] pv;
  logic dir_up;
  int checks, errors;
  bit done;

  gec_counter #(.PV_W(PV_W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .idx_z(idx_z), .sw_clr(sw_clr), .hold(hold), .clr_mode(clr_mode),
    .scan(scan), .pv(pv), .dir_up(dir_up)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input int req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic u, d, z, s, h, m, sc);
    cnt_up = u; cnt_dn = d; idx_z = z; sw_clr = s; hold = h; clr_mode = m; scan = sc;
  endtask

  task automatic step_check(input logic u, d, z, s, h, m, sc,
                            input int epv, input logic edir, input int req);
    drive(u, d, z, s, h, m, sc);
    @(negedge clk);
    check(req, int'(pv), epv, "pv");
    check(req, int'(dir_up), int'(edir), "dir_up");
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    drive(0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(1, int'(pv), 0, "pv in reset");
    check(1, int'(dir_up), 0, "dir_up in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1, int'(pv), 0, "pv after release");

    for (int i = 0; i < NV; i++) begin
      step_check(VEC[i].up, VEC[i].dn, VEC[i].z, VEC[i].sw, VEC[i].hold,
                 VEC[i].mode, VEC[i].scan, VEC[i].pv, VEC[i].dir, VEC[i].req);
    end
    drive(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);

    // R3 / R5: software clear acts while hold is set (pv 0 -> 1 -> 0)
    step_check(1, 0, 0, 0, 0, 0, 0, 1, 1'b1, 2);
    step_check(1, 0, 0, 1, 1, 0, 1, 0, 1'b1, 3);
    // R7: index mode with sw_clr set, hold overridden for a down step
    step_check(0, 1, 0, 1, 1, 1, 0, -1, 1'b1, 7);
    // R5: hold with sw_clr low in index mode
    step_check(0, 1, 0, 0, 1, 1, 0, -1, 1'b1, 5);
    drive(0, 0, 0, 0, 0, 0, 0);

    // R1: reset in the middle of a run
    rst_n = 1'b0;
    @(negedge clk);
    check(1, int'(pv), 0, "pv mid-run reset");
    check(1, int'(dir_up), 0, "dir_up mid-run reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R3: sample memory reads 0 after reset, so a held 1 clears at first scan
    step_check(1, 0, 0, 0, 0, 0, 0, 1, 1'b0, 2);
    step_check(0, 0, 0, 1, 0, 0, 1, 0, 1'b1, 3);

    done = 1;
    finish_run();
  end
endmodule